// File: doc/BRIEF.md
# Random Number Generator Control and Interrupt Unit

This block is the register-mapped control logic of a hardware random number generator. Software drives it through a 32-bit read/write register port. The block runs two timed operations, a self-test and a seed generation. It records when each one finishes and whether it failed, and it raises one maskable interrupt line. After a successful seed it keeps a small output FIFO of 32-bit random words filled. The words come from a deterministic xorshift generator, so results repeat exactly in simulation.

A normal session runs in this order:
1. Software unmasks the interrupt and starts a self-test.
2. It waits for the interrupt and clears it.
3. It issues seed commands until one finishes without a statistical error.
4. It drains words from the data register.

With automatic seeding enabled, the block starts a new seed by itself after a fixed number of served words. A failed seed makes the error visible. It also flushes the FIFO and stops further refills until a later seed succeeds.

Top module: `trng_ctl`

## Requirements
- R1: The version register (byte offset 0x00) reads the type code in bits 31:28, the major revision in bits 15:8 and the minor revision in bits 7:0, with all other bits zero.
- R2: The control register (0x08) holds auto-seed enable in bit 4, the done-interrupt mask in bit 5 and the error-interrupt mask in bit 6. It resets to 0x60, and its other bits read as zero.
- R3: Writing bit 0 of the command register (0x04) starts a self-test. Status bit 4 sets after TEST_CYC cycles. The command register always reads zero.
- R4: Writing command bit 1 starts a seed, and status bit 5 sets after SEED_CYC cycles. Seed attempt k (counted from reset, k < 8) fails when FAIL_MASK[k] is 1. A failure makes the error register (0x10) read 0x00000008 and sets status bit 16.
- R5: A self-test or seed command issued while an operation is running is ignored.
- R6: `irq` is high exactly when an unmasked done flag or an unmasked error is pending, delayed by one register stage.
- R7: Command bit 4 clears both done flags only when no error is latched. While an error is latched, it has no effect.
- R8: Command bit 5 clears the error register and both done flags.
- R9: Status bits 11:8 give the FIFO level, up to DEPTH. The FIFO fills only after a successful seed. A seed failure empties it and keeps the level at zero until a later seed succeeds.
- R10: Each read of the data register (0x14) with a non-zero level pops one word. Words come out in generator order: the first is GEN_INIT, and each following word is the xorshift32 step (shift left 13, right 17, left 5, each XORed in) of the previous one.
- R11: A data read at level zero returns zero and leaves the level at zero.
- R12: While control bit 4 is set, every RESEED_WORDS-th served word starts a seed automatically, which ends with status bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest state to reach is a seed failure while the FIFO is full of good words. Only that case shows the flush, the frozen level and the resumed word order together. The stimulus sets the failure pattern so that the first and third seed attempts fail. It lets the FIFO fill after the second attempt and drains part of it. It then reseeds into the failure, and the scoreboard drops its model contents at that point. The automatic reseed is reached by reducing the word-count parameter and reading exactly that many words with auto-seeding on.

// File: rtl/trng_pkg.sv
`timescale 1ns/1ps
package trng_pkg;
  localparam logic [7:0] OFF_VER  = 8'h00;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_CTL  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_ERR  = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h14;

  localparam int CMD_TEST = 0;
  localparam int CMD_SEED = 1;
  localparam int CMD_CLRI = 4;
  localparam int CMD_CLRE = 5;

  localparam int CTL_AUTO  = 4;
  localparam int CTL_MDONE = 5;
  localparam int CTL_MERR  = 6;

  localparam int ST_TDONE = 4;
  localparam int ST_SDONE = 5;
  localparam int ST_LVL   = 8;
  localparam int ST_ERR   = 16;

  localparam logic [31:0] ERR_STAT_VAL = 32'h0000_0008;

  typedef enum logic [1:0] {OP_NONE, OP_TEST, OP_SEED} op_e;
endpackage

// File: rtl/trng_xorshift.sv
`timescale 1ns/1ps
module trng_xorshift #(
  parameter logic [31:0] INIT = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [31:0] word
);
  logic [31:0] s, a, b, c;

  always_comb begin
    a = s ^ (s << 13);
    b = a ^ (a >> 17);
    c = b ^ (b << 5);
  end

  always_ff @(posedge clk) begin
    if (rst)      s <= INIT;
    else if (adv) s <= c;
  end

  assign word = s;
endmodule

// File: rtl/trng_fifo.sv
`timescale 1ns/1ps
module trng_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic [LVL_W-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             do_push, do_pop;

  assign do_push = push && (cnt != LVL_W'(DEPTH)) && !flush;
  assign do_pop  = pop && (cnt != '0) && !flush;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= inc(wp);
      if (do_pop)  rp <= inc(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign level = cnt;
endmodule

// File: rtl/trng_seq.sv
`timescale 1ns/1ps
module trng_seq
  import trng_pkg::*;
#(
  parameter int         TEST_CYC  = 64,
  parameter int         SEED_CYC  = 256,
  parameter logic [7:0] FAIL_MASK = 8'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic start_test,
  input  logic start_seed,
  output logic busy,
  output logic fin,
  output op_e  fin_op,
  output logic fin_fail
);
  localparam int MAXC = (TEST_CYC > SEED_CYC) ? TEST_CYC : SEED_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  op_e           op;
  logic [CW-1:0] cnt;
  logic [3:0]    attempt;
  logic          seed_bad;

  assign seed_bad = (attempt < 4'd8) && FAIL_MASK[attempt[2:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op       <= OP_NONE;
      cnt      <= '0;
      fin      <= 1'b0;
      fin_op   <= OP_NONE;
      fin_fail <= 1'b0;
      attempt  <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start_test) begin
          busy <= 1'b1;
          op   <= OP_TEST;
          cnt  <= CW'(TEST_CYC - 1);
        end else if (start_seed) begin
          busy <= 1'b1;
          op   <= OP_SEED;
          cnt  <= CW'(SEED_CYC - 1);
        end
      end else if (cnt == '0) begin
        busy     <= 1'b0;
        fin      <= 1'b1;
        fin_op   <= op;
        fin_fail <= (op == OP_SEED) && seed_bad;
        if (op == OP_SEED && attempt != 4'd8) attempt <= attempt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trng_ctl.sv
`timescale 1ns/1ps
module trng_ctl
  import trng_pkg::*;
#(
  parameter int         ADDR_W       = 5,
  parameter int         DEPTH        = 8,
  parameter int         TEST_CYC     = 64,
  parameter int         SEED_CYC     = 256,
  parameter int         RESEED_WORDS = 5 * (1 << 20),
  parameter logic [7:0] FAIL_MASK    = 8'h01,
  parameter logic [31:0] GEN_INIT    = 32'hACE1_2468,
  parameter logic [3:0] TYPE_CODE    = 4'h2,
  parameter logic [7:0] REV_MAJ      = 8'h01,
  parameter logic [7:0] REV_MIN      = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int AC_W  = $clog2(RESEED_WORDS + 1);

  logic ctrl_auto, ctrl_mdone, ctrl_merr;
  logic st_done, sd_done, err_stat, seeded, auto_req;
  logic [AC_W-1:0] auto_cnt;
  logic cmd_wr, ctl_wr, data_rd;
  logic c_test, c_seed, c_clri, c_clre;
  logic busy, fin, fin_fail;
  op_e  fin_op;
  logic push, pop, flush;
  logic [31:0] gen_word, fifo_dout, rd_mux, stat_word;
  logic [LVL_W-1:0] fifo_level, level_rep;
  logic unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:7], bus_wdata[3:2]};

  assign cmd_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
  assign data_rd = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));
  assign c_test  = cmd_wr && bus_wdata[CMD_TEST];
  assign c_seed  = cmd_wr && bus_wdata[CMD_SEED];
  assign c_clri  = cmd_wr && bus_wdata[CMD_CLRI];
  assign c_clre  = cmd_wr && bus_wdata[CMD_CLRE];

  trng_seq #(.TEST_CYC(TEST_CYC), .SEED_CYC(SEED_CYC), .FAIL_MASK(FAIL_MASK)) u_seq (
    .clk(clk), .rst(rst), .start_test(c_test), .start_seed(c_seed || auto_req),
    .busy(busy), .fin(fin), .fin_op(fin_op), .fin_fail(fin_fail));

  assign flush = fin && (fin_op == OP_SEED) && fin_fail;
  assign push  = seeded && !err_stat && !busy && !fin;
  assign pop   = data_rd && (fifo_level != '0);

  trng_xorshift #(.INIT(GEN_INIT)) u_gen (
    .clk(clk), .rst(rst), .adv(push && (fifo_level != LVL_W'(DEPTH))), .word(gen_word));

  trng_fifo #(.DW(32), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .din(gen_word),
    .pop(pop), .dout(fifo_dout), .level(fifo_level));

  assign level_rep = err_stat ? '0 : fifo_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_auto  <= 1'b0;
      ctrl_mdone <= 1'b1;
      ctrl_merr  <= 1'b1;
      st_done    <= 1'b0;
      sd_done    <= 1'b0;
      err_stat   <= 1'b0;
      seeded     <= 1'b0;
      auto_req   <= 1'b0;
      auto_cnt   <= '0;
    end else begin
      if (ctl_wr) begin
        ctrl_auto  <= bus_wdata[CTL_AUTO];
        ctrl_mdone <= bus_wdata[CTL_MDONE];
        ctrl_merr  <= bus_wdata[CTL_MERR];
      end
      if (c_clre) begin
        err_stat <= 1'b0;
        st_done  <= 1'b0;
        sd_done  <= 1'b0;
      end else if (c_clri && !err_stat) begin
        st_done <= 1'b0;
        sd_done <= 1'b0;
      end
      if (fin && fin_op == OP_TEST) st_done <= 1'b1;
      if (fin && fin_op == OP_SEED) begin
        sd_done <= 1'b1;
        if (fin_fail) begin
          err_stat <= 1'b1;
          seeded   <= 1'b0;
        end else begin
          seeded <= 1'b1;
        end
      end
      if (auto_req && !busy && !c_test) auto_req <= 1'b0;
      if (pop && ctrl_auto) begin
        if (auto_cnt == AC_W'(RESEED_WORDS - 1)) begin
          auto_cnt <= '0;
          auto_req <= 1'b1;
        end else begin
          auto_cnt <= auto_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[ST_TDONE] = st_done;
    stat_word[ST_SDONE] = sd_done;
    stat_word[ST_LVL +: 4] = 4'(level_rep);
    stat_word[ST_ERR] = err_stat;
    case (bus_addr)
      ADDR_W'(OFF_VER):  rd_mux = {TYPE_CODE, 12'h000, REV_MAJ, REV_MIN};
      ADDR_W'(OFF_CTL):  rd_mux = {25'h0, ctrl_merr, ctrl_mdone, ctrl_auto, 4'h0};
      ADDR_W'(OFF_STAT): rd_mux = stat_word;
      ADDR_W'(OFF_ERR):  rd_mux = err_stat ? ERR_STAT_VAL : 32'h0;
      ADDR_W'(OFF_DATA): rd_mux = (fifo_level != '0) ? fifo_dout : 32'h0;
      default:           rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : 32'h0;
      irq       <= ((st_done || sd_done) && !ctrl_mdone) || (err_stat && !ctrl_merr);
    end
  end
endmodule

// File: rtl/trng_ctl_chk.sv
`timescale 1ns/1ps
module trng_ctl_chk
  import trng_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              ctrl_mdone,
  input logic              ctrl_merr,
  input logic              st_done,
  input logic              sd_done,
  input logic              err_stat,
  input logic              busy,
  input logic              fin,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_clri,
  input logic              wd_clre,
  input logic [31:0]       bus_rdata
);
  logic wr_cmd;
  assign wr_cmd = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_mdone && ctrl_merr) |=> !irq);

  assert_irq_err_R6: assert property (@(posedge clk) disable iff (rst)
    (err_stat && !ctrl_merr) |=> irq);

  assert_clri_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wd_clri && !wd_clre && err_stat && (st_done || sd_done)) |=> (st_done || sd_done));

  assert_clre_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && wd_clre && !fin) |=> !err_stat);

  assert_err_empty_R9: assert property (@(posedge clk) disable iff (rst)
    err_stat |-> (fifo_level == '0));

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_DATA) && fifo_level == '0) |=> (bus_rdata == 32'h0));

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || fin));
endmodule

bind trng_ctl trng_ctl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ctrl_mdone(ctrl_mdone), .ctrl_merr(ctrl_merr),
  .st_done(st_done), .sd_done(sd_done), .err_stat(err_stat), .busy(busy), .fin(fin),
  .fifo_level(fifo_level), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .wd_clri(bus_wdata[4]), .wd_clre(bus_wdata[5]), .bus_rdata(bus_rdata));

// File: tb/trng_ctl_bench.sv
`timescale 1ns/1ps
module trng_ctl_bench;
  localparam int          TC   = 20;
  localparam int          SC   = 30;
  localparam int          DP   = 8;
  localparam int          RW   = 12;
  localparam logic [31:0] INIT = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trng_ctl #(.ADDR_W(5), .DEPTH(DP), .TEST_CYC(TC), .SEED_CYC(SC), .RESEED_WORDS(RW),
             .FAIL_MASK(8'b0000_0101), .GEN_INIT(INIT), .TYPE_CODE(4'h2),
             .REV_MAJ(8'h02), .REV_MIN(8'h01)) u_trng_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference generator and FIFO model
  logic [31:0] gen = INIT;
  logic [31:0] mq[$];
  bit          model_seeded = 0;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic model_push();
    mq.push_back(gen);
    gen = xs(gen);
  endtask

  // scoreboard
  logic [31:0] sb_q[$];
  string       sb_tag[$];
  logic [31:0] rsp;
  event        rsp_ev;

  task automatic rd_data(input string tag);
    logic [31:0] d;
    if (mq.size() > 0) begin
      sb_q.push_back(mq.pop_front());
      if (model_seeded) model_push();
    end else begin
      sb_q.push_back(32'h0);
    end
    sb_tag.push_back(tag);
    bus_read(5'h14, d);
    rsp = d;
    ->rsp_ev;
  endtask

  initial begin
    forever begin
      @(rsp_ev);
      check32(sb_tag.pop_front(), rsp, sb_q.pop_front());
    end
  end

  task automatic seed_and_wait(output logic [31:0] st);
    bus_write(5'h04, 32'h2);
    idle(SC + DP + 10);
    bus_read(5'h0C, st);
  endtask

  initial begin
    logic [31:0] d;
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(2);

    bus_read(5'h00, d); check32("R1 version", d, 32'h2000_0201);
    bus_read(5'h08, d); check32("R2 control reset", d, 32'h60);
    bus_read(5'h0C, d); check32("R9 status reset", d, 32'h0);
    bus_read(5'h10, d); check32("R4 error reset", d, 32'h0);
    check32("R6 irq reset", {31'h0, irq}, 32'h0);

    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, d); check32("R2 control writable bits", d, 32'h70);
    bus_write(5'h08, 32'h0);
    bus_read(5'h08, d); check32("R2 control cleared", d, 32'h0);

    rd_data("R11 empty read");
    bus_read(5'h0C, d); check32("R11 level after empty read", d, 32'h0);

    // self-test, with a seed command arriving while busy
    bus_write(5'h04, 32'h1);
    bus_write(5'h04, 32'h2);
    bus_read(5'h04, d); check32("R3 command reads zero", d, 32'h0);
    bus_read(5'h0C, d); check32("R3 not done early", d, 32'h0);
    idle(TC + 40);
    bus_read(5'h0C, d); check32("R3 R5 test done, seed ignored", d, 32'h10);
    check32("R6 irq on done", {31'h0, irq}, 32'h1);
    bus_write(5'h08, 32'h20);
    idle(2);
    check32("R6 irq masked done", {31'h0, irq}, 32'h0);
    bus_write(5'h08, 32'h0);
    bus_write(5'h04, 32'h10);
    idle(2);
    bus_read(5'h0C, d); check32("R7 clear without error", d, 32'h0);
    check32("R6 irq after clear", {31'h0, irq}, 32'h0);

    // attempt 0 fails
    seed_and_wait(d);
    check32("R4 failed seed status", d, 32'h0001_0020);
    bus_read(5'h10, d); check32("R4 error code", d, 32'h8);
    bus_write(5'h04, 32'h10);
    idle(2);
    bus_read(5'h0C, d); check32("R7 clear blocked by error", d, 32'h0001_0020);
    check32("R7 irq kept", {31'h0, irq}, 32'h1);
    bus_write(5'h08, 32'h60);
    idle(2);
    check32("R6 irq fully masked", {31'h0, irq}, 32'h0);
    bus_write(5'h08, 32'h0);
    bus_write(5'h04, 32'h20);
    idle(2);
    bus_read(5'h0C, d); check32("R8 status after clear error", d, 32'h0);
    bus_read(5'h10, d); check32("R8 error cleared", d, 32'h0);
    check32("R8 irq cleared", {31'h0, irq}, 32'h0);

    // attempt 1 succeeds
    seed_and_wait(d);
    check32("R9 full after good seed", d, 32'h0000_0820);
    model_seeded = 1;
    for (int i = 0; i < DP; i++) model_push();
    bus_write(5'h04, 32'h10);
    for (int i = 0; i < 5; i++) rd_data("R10 word order");
    idle(10);
    bus_read(5'h0C, d); check32("R9 refilled", d, 32'h0000_0800);

    // attempt 2 fails with a full FIFO
    seed_and_wait(d);
    check32("R9 flush on failure", d, 32'h0001_0020);
    mq.delete();
    model_seeded = 0;
    rd_data("R11 read after flush");
    bus_write(5'h04, 32'h20);
    idle(DP + 4);
    bus_read(5'h0C, d); check32("R9 no refill before good seed", d, 32'h0);

    // attempt 3 succeeds, then automatic reseed
    seed_and_wait(d);
    check32("R9 full after reseed", d, 32'h0000_0820);
    model_seeded = 1;
    for (int i = 0; i < DP; i++) model_push();
    bus_write(5'h04, 32'h10);
    bus_write(5'h08, 32'h10);
    for (int i = 0; i < RW - 1; i++) rd_data("R10 word order before auto seed");
    idle(DP + 4);
    bus_read(5'h0C, d); check32("R12 no auto seed yet", d, 32'h0000_0800);
    rd_data("R10 word triggering auto seed");
    idle(SC + DP + 10);
    bus_read(5'h0C, d); check32("R12 auto seed done", d, 32'h0000_0820);
    for (int i = 0; i < 4; i++) rd_data("R10 word order after auto seed");
    idle(4);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule